// File: doc/BRIEF.md
# Zone Access Permission Checker

This block rules on a memory access after address translation has already found a matching entry. It takes the entry's attribute byte, the entry's execute and write permission bits, a 32-bit zone protection word, the current privilege state (user or supervisor) and the kind of access (instruction fetch, load or store). It returns a grant or a fault, a fault class and the rights granted (read, write).

Each translation entry names one of sixteen protection zones. The zone protection word holds a 2-bit code for each zone. That code can send the decision to the entry's own permission bits, refuse user accesses outright, or grant full rights without looking at the entry. Which of these happens depends on the privilege state.

The verdict is registered. It appears one cycle after the request, marked by a single-cycle strobe. A cycle without a translation hit produces no verdict at all.

Top module: `zone_perm_check`

## Requirements
- R1: One clock after `hit_valid` is high, `rsp_valid` is high for exactly one cycle. One clock after `hit_valid` is low, `rsp_valid` is low.
- R2: While `rsp_valid` is low, `rsp_grant`, `rsp_fault`, `rsp_rd` and `rsp_wr` are all 0 and `rsp_class` is 2'b00. A cycle with no hit therefore grants nothing and raises no fault.
- R3: The zone number is `attr[7:4]`. The zone's code is `zone_reg[31-2*zone -: 2]`, so zone 0 uses bits [31:30] and zone 15 uses bits [1:0].
- R4: With zone code 0 and `user_mode`=1, the access faults with class 2'b01 (zone deny) and no rights.
- R5: With zone code 0 and `user_mode`=0, or with zone code 1 in either state, the verdict comes from the entry check (R8 to R10).
- R6: With zone code 2, a user access takes the entry check. A supervisor access is granted with read and write rights.
- R7: With zone code 3, every access is granted with read and write rights, whatever the entry bits are.
- R8: In the entry check, a fetch (`acc_type`=2'b00) with `ent_exec`=0 faults with class 2'b11 (execute protect) and no rights.
- R9: In the entry check, a store (`acc_type`=2'b10) with `ent_write`=0 faults with class 2'b10 (write protect) and no rights. A store with `ent_write`=1 is granted with read and write rights.
- R10: In the entry check, a load (`acc_type`=2'b01), or a fetch with `ent_exec`=1, is granted with `rsp_rd`=1 and `rsp_wr`=`ent_write`.
- R11: When `rsp_valid` is high, exactly one of `rsp_grant` and `rsp_fault` is high. `rsp_class` is 2'b00 exactly when the access is granted. `acc_type`=2'b11 is handled as a load.
- R12: While `rst_n` is low and after it is released, all outputs are 0 until a request is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A translation hit is presented this cycle |
| attr | input | 8 | Attribute byte of the hit entry; bits [7:4] select the zone |
| ent_exec | input | 1 | Entry allows instruction fetch |
| ent_write | input | 1 | Entry allows stores |
| zone_reg | input | 32 | Zone protection word, 2 bits per zone, zone 0 in the top bits |
| user_mode | input | 1 | 1 = user state, 0 = supervisor state |
| acc_type | input | 2 | 00 fetch, 01 load, 10 store, 11 treated as load |
| rsp_valid | output | 1 | Verdict strobe, one cycle per request |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_class | output | 2 | 00 granted, 01 zone deny, 10 write protect, 11 execute protect |
| rsp_rd | output | 1 | Read right granted |
| rsp_wr | output | 1 | Write right granted |

## Verification
The bench builds the block with its default parameters: sixteen zones of 2-bit codes and the zone select at attribute bits [7:4]. This lets it place a code in zone 0 (the top bits), in a middle zone and in zone 15 (the bottom bits). The other zones are filled with unrelated codes, so a wrong shift direction or a wrong field width picks up a different code and shows up as a wrong verdict. For each of those zones the bench runs every combination of code, privilege state, access type and entry bits. It then adds the reserved access type, cycles without a hit placed between requests, and back-to-back requests with pseudo-random zone words.

// File: rtl/zperm_pkg.sv
package zperm_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_ZONE  = 2'b01,
        FLT_WPROT = 2'b10,
        FLT_XPROT = 2'b11
    } flt_e;

    typedef enum logic [1:0] {
        ZC_NOUSER = 2'b00,
        ZC_ENTRY  = 2'b01,
        ZC_SUPALL = 2'b10,
        ZC_OPEN   = 2'b11
    } zcode_e;

    typedef struct packed {
        logic valid;
        logic grant;
        logic fault;
        flt_e cls;
        logic rd;
        logic wr;
    } verdict_t;

endpackage

// File: rtl/zperm_zone_pick.sv
module zperm_zone_pick #(
    parameter int ZONES  = 16,
    parameter int CODE_W = 2,
    parameter int SEL_W  = $clog2(ZONES),
    parameter int ZPR_W  = ZONES * CODE_W
) (
    input  logic [ZPR_W-1:0]  zone_reg,
    input  logic [SEL_W-1:0]  zone_sel,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] field [ZONES];

    // zone 0 sits in the most significant field
    for (genvar g = 0; g < ZONES; g++) begin : g_field
        assign field[g] = zone_reg[ZPR_W-1-g*CODE_W -: CODE_W];
    end

    assign code = field[zone_sel];
endmodule

// File: rtl/zperm_rule.sv
module zperm_rule
    import zperm_pkg::*;
(
    input  logic [1:0] code,
    input  logic       user_mode,
    input  logic [1:0] acc_type,
    input  logic       ent_exec,
    input  logic       ent_write,
    output verdict_t   verdict
);
    logic deny_zone;
    logic open_all;

    always_comb begin
        deny_zone = (code == ZC_NOUSER) && user_mode;
        open_all  = (code == ZC_OPEN) || ((code == ZC_SUPALL) && !user_mode);
    end

    always_comb begin
        verdict = '0;
        if (deny_zone) begin
            verdict.fault = 1'b1;
            verdict.cls   = FLT_ZONE;
        end else if (open_all) begin
            verdict.grant = 1'b1;
            verdict.rd    = 1'b1;
            verdict.wr    = 1'b1;
        end else begin
            unique case (acc_type)
                ACC_FETCH: begin
                    if (ent_exec) begin
                        verdict.grant = 1'b1;
                        verdict.rd    = 1'b1;
                        verdict.wr    = ent_write;
                    end else begin
                        verdict.fault = 1'b1;
                        verdict.cls   = FLT_XPROT;
                    end
                end
                ACC_STORE: begin
                    if (ent_write) begin
                        verdict.grant = 1'b1;
                        verdict.rd    = 1'b1;
                        verdict.wr    = 1'b1;
                    end else begin
                        verdict.fault = 1'b1;
                        verdict.cls   = FLT_WPROT;
                    end
                end
                default: begin
                    verdict.grant = 1'b1;
                    verdict.rd    = 1'b1;
                    verdict.wr    = ent_write;
                end
            endcase
        end
    end
endmodule

// File: rtl/zone_perm_check.sv
module zone_perm_check
    import zperm_pkg::*;
#(
    parameter int ZONES    = 16,
    parameter int CODE_W   = 2,
    parameter int ATTR_W   = 8,
    parameter int ZSEL_LSB = 4,
    parameter int SEL_W    = $clog2(ZONES),
    parameter int ZPR_W    = ZONES * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [ATTR_W-1:0] attr,
    input  logic              ent_exec,
    input  logic              ent_write,
    input  logic [ZPR_W-1:0]  zone_reg,
    input  logic              user_mode,
    input  logic [1:0]        acc_type,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic [1:0]        rsp_class,
    output logic              rsp_rd,
    output logic              rsp_wr
);
    logic [SEL_W-1:0]  zone_sel;
    logic [CODE_W-1:0] zone_code;
    verdict_t          rule_v;
    verdict_t          st_d, st_q;

    assign zone_sel = attr[ZSEL_LSB +: SEL_W];

    zperm_zone_pick #(
        .ZONES (ZONES),
        .CODE_W(CODE_W)
    ) pick_i (
        .zone_reg(zone_reg),
        .zone_sel(zone_sel),
        .code    (zone_code)
    );

    zperm_rule rule_i (
        .code     (zone_code[1:0]),
        .user_mode(user_mode),
        .acc_type (acc_type),
        .ent_exec (ent_exec),
        .ent_write(ent_write),
        .verdict  (rule_v)
    );

    always_comb begin
        st_d = '0;
        if (hit_valid) begin
            st_d       = rule_v;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_grant = st_q.grant;
    assign rsp_fault = st_q.fault;
    assign rsp_class = st_q.cls;
    assign rsp_rd    = st_q.rd;
    assign rsp_wr    = st_q.wr;
endmodule

// File: rtl/zone_perm_check_sva.sv
module zone_perm_check_sva #(
    parameter int ZONES = 16,
    parameter int ZPR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_valid,
    input logic [7:0]       attr,
    input logic             ent_write,
    input logic [ZPR_W-1:0] zone_reg,
    input logic             user_mode,
    input logic [1:0]       acc_type,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             rsp_fault,
    input logic [1:0]       rsp_class,
    input logic             rsp_rd,
    input logic             rsp_wr
);
    logic [1:0] code_now;
    assign code_now = zone_reg[ZPR_W-1-2*attr[7:4] -: 2];

    assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> rsp_valid);
    assert_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> !rsp_valid);
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_fault && rsp_class == 2'b00 && !rsp_rd && !rsp_wr));
    assert_zone_deny_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'b01) |-> $past(user_mode));
    assert_open_zone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && code_now == 2'b11) |=> (rsp_grant && rsp_rd && rsp_wr));
    assert_xprot_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'b11) |-> $past(acc_type) == 2'b00);
    assert_wprot_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'b10) |-> ($past(acc_type) == 2'b10 && !$past(ent_write)));
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_grant, rsp_fault}) == 1 && (rsp_grant == (rsp_class == 2'b00))));
endmodule

bind zone_perm_check zone_perm_check_sva #(.ZONES(ZONES), .ZPR_W(ZPR_W)) sva_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_valid(hit_valid),
    .attr     (attr),
    .ent_write(ent_write),
    .zone_reg (zone_reg),
    .user_mode(user_mode),
    .acc_type (acc_type),
    .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant),
    .rsp_fault(rsp_fault),
    .rsp_class(rsp_class),
    .rsp_rd   (rsp_rd),
    .rsp_wr   (rsp_wr)
);

// File: tb/zone_perm_check_tb_top.sv
module zone_perm_check_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic [7:0]  attr = '0;
    logic        ent_exec = 1'b0;
    logic        ent_write = 1'b0;
    logic [31:0] zone_reg = '0;
    logic        user_mode = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        rsp_valid, rsp_grant, rsp_fault, rsp_rd, rsp_wr;
    logic [1:0]  rsp_class;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    // expected {valid, grant, fault, class[1:0], rd, wr}
    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    zone_perm_check dut_i (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .attr(attr),
        .ent_exec(ent_exec), .ent_write(ent_write), .zone_reg(zone_reg),
        .user_mode(user_mode), .acc_type(acc_type), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_class(rsp_class),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr)
    );

    // reference verdict, built from the requirements
    function automatic logic [6:0] model(input logic hit, input logic [7:0] a,
                                         input logic ex, input logic w,
                                         input logic [31:0] zr, input logic usr,
                                         input logic [1:0] acc, output string tag);
        int z;
        logic [1:0] c;
        z = int'(a[7:4]);                     // R3
        c = zr[31-2*z -: 2];
        if (!hit) begin tag = "R2"; return 7'b0; end
        if (c == 2'd0 && usr) begin tag = "R4"; return {1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0}; end
        if (c == 2'd3) begin tag = "R7"; return {1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1}; end
        if (c == 2'd2 && !usr) begin tag = "R6"; return {1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1}; end
        // entry check path (R5)
        if (acc == 2'b00) begin
            if (!ex) begin tag = "R8"; return {1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0}; end
            tag = "R10"; return {1'b1, 1'b1, 1'b0, 2'b00, 1'b1, w};
        end
        if (acc == 2'b10) begin
            tag = "R9";
            if (!w) return {1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0};
            return {1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1};
        end
        tag = (acc == 2'b11) ? "R11" : "R5";
        return {1'b1, 1'b1, 1'b0, 2'b00, 1'b1, w};
    endfunction

    task automatic drive(input logic hit, input logic [7:0] a, input logic ex,
                         input logic w, input logic [31:0] zr, input logic usr,
                         input logic [1:0] acc);
        string t;
        @(negedge clk);
        hit_valid = hit; attr = a; ent_exec = ex; ent_write = w;
        zone_reg = zr; user_mode = usr; acc_type = acc;
        exp_q.push_back(model(hit, a, ex, w, zr, usr, acc, t));
        tag_q.push_back(t);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: compare one expected item per driven cycle (R1 timing)
    initial begin
        logic [6:0] e, act;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (running && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {rsp_valid, rsp_grant, rsp_fault, rsp_class, rsp_rd, rsp_wr};
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s/R1: got %b expected %b (v,g,f,cls,rd,wr)", t, act, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int zl[3];
        logic [31:0] base, zr, lf;
        zl[0] = 0; zl[1] = 5; zl[2] = 15;
        repeat (3) @(negedge clk);
        // R12: outputs cleared in and after reset
        checks++;
        if ({rsp_valid, rsp_grant, rsp_fault, rsp_class, rsp_rd, rsp_wr} !== 7'b0) begin
            errors++;
            $display("FAIL R12: got %b expected %b",
                     {rsp_valid, rsp_grant, rsp_fault, rsp_class, rsp_rd, rsp_wr}, 7'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({rsp_valid, rsp_grant, rsp_fault, rsp_class, rsp_rd, rsp_wr} !== 7'b0) begin
            errors++;
            $display("FAIL R12: got %b expected %b after release",
                     {rsp_valid, rsp_grant, rsp_fault, rsp_class, rsp_rd, rsp_wr}, 7'b0);
        end
        running = 1'b1;
        // R3..R10: code, privilege, access type and entry bits across three zones
        foreach (zl[i]) begin
            for (int c = 0; c < 4; c++) begin
                base = 32'hB4E1_7D28 ^ {16{2'(3 - c)}};
                zr = base;
                zr[31-2*zl[i] -: 2] = 2'(c);
                for (int u = 0; u < 2; u++)
                    for (int acc = 0; acc < 3; acc++)
                        for (int eb = 0; eb < 4; eb++)
                            drive(1'b1, {4'(zl[i]), 4'hA}, eb[1], eb[0], zr, u[0], 2'(acc));
            end
        end
        // R11: reserved access type behaves as load
        drive(1'b1, 8'h30, 1'b0, 1'b0, 32'h0500_0000, 1'b0, 2'b11);
        drive(1'b1, 8'h30, 1'b0, 1'b1, 32'h0500_0000, 1'b1, 2'b11);
        // R2: no hit between and around requests
        drive(1'b0, 8'hF0, 1'b0, 1'b0, 32'h0, 1'b1, 2'b10);
        drive(1'b1, 8'h00, 1'b1, 1'b1, 32'hC000_0000, 1'b1, 2'b10);
        drive(1'b0, 8'h00, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 2'b00);
        drive(1'b0, 8'h00, 1'b1, 1'b1, 32'h0, 1'b1, 2'b00);
        // back-to-back pseudo-random traffic
        lf = 32'h1234_5678;
        for (int k = 0; k < 200; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            drive(lf[3] | lf[9], lf[31:24], lf[5], lf[6], lf ^ 32'h9E37_79B9,
                  lf[7], lf[11:10]);
        end
        drive(1'b0, 8'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'b00);
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule